// File: doc/BRIEF.md
# External Interrupt Line Controller

This block gathers a set of interrupt request lines (40 by default) from GPIO pin selectors and serial-port blocks and drives one interrupt output per line toward the CPU interrupt controller. Each line is one of two kinds, fixed at build time by a read-only mask parameter. A direct line hands its input level straight to its output. A configurable line passes through edge detection. That detection uses per-line rising and falling trigger selects and a stored last-level bit. A detected edge sets a sticky pending bit and raises the line's output for one clock.

Software sees the trigger selects, a software-trigger register and the pending register through a plain register port. The port uses byte addresses inside a 0x400-byte window, and the lines are grouped into 32-bit banks. Bank `b` holds lines `32*b` up to `32*b+31`, with line `32*b+n` at bit `n`. Every bank has the same four registers at base `0x20*b`: rising select at +0x08, falling select at +0x0C, software trigger at +0x10 and pending at +0x14. Bank 1 therefore has its software trigger at 0x30 and its pending register at 0x34. Writes take effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset every trigger-select, software-trigger and pending bit reads 0, every stored level is 0, and all configurable outputs are low.
- R2: Register offsets and bit positions follow the bank layout above. An edge on line 35 sets bit 3 of the bank-1 pending register at 0x34 and leaves bank 0 untouched.
- R3: A direct line (by default lines 26, 29 and 31) drives its output with the same level as its input in the same cycle and never sets a pending bit.
- R4: The bits of direct lines read 0 in the trigger-select, software-trigger and pending registers, and writes to them have no effect, including software-trigger writes.
- R5: A configurable line with its rising select set, a stored level of 0 and an input of 1 at a clock edge sets its pending bit and drives its output high for exactly the following cycle. Its stored level becomes 1, so an input that stays high does not fire again.
- R6: A configurable line with its falling select set, a stored level of 1 and an input of 0 at a clock edge sets its pending bit and pulses its output in the same way. Its stored level becomes 0.
- R7: The stored level moves only in a direction whose trigger is selected. An input change in a direction that is not selected does nothing. A rising-only line that goes low and then high again therefore does not fire a second time, and a falling-only line never fires.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Without a write, a pending bit never clears.
- R9: Writing 1 to a software-trigger bit of a configurable line sets its pending bit and pulses its output in the cycle after the write. The software-trigger bit reads 1 until that pending bit is cleared.
- R10: Bits of the last bank above the highest line (bits 8 to 31 of bank 1 by default) read 0 and ignore writes.
- R11: Offsets outside the four registers of each bank, and misaligned byte addresses, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Interrupt request levels, one per line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte address inside the register window |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | NUM_LINES | Interrupt outputs toward the CPU interrupt controller |

## Verification
The state hardest to reach from the ports is a stored level that no longer matches the input. This happens when only one trigger direction is selected, and it is visible only as a missing second pulse. The stimulus enables rising-only on one line and falling-only on another. It toggles each input through both levels and expects silence where a plain edge detector would fire. Software-trigger timing and the partial width of the last bank are reached with register writes alone, and the results are read back through the pending and software-trigger registers.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int BANK_W     = 32;
  localparam int WIN_ADDR_W = 10;   // 0x400-byte window
  localparam int BANK_SPAN  = 32;   // bytes between bank bases

  // word index (addr[4:2]) of each register inside a bank
  localparam logic [2:0] W_RISE = 3'd2;
  localparam logic [2:0] W_FALL = 3'd3;
  localparam logic [2:0] W_SWT  = 3'd4;
  localparam logic [2:0] W_PEND = 3'd5;

  typedef enum logic [2:0] {
    RK_NONE, RK_RISE, RK_FALL, RK_SWT, RK_PEND
  } reg_kind_e;

  function automatic int bank_lines(int total, int b);
    int rem;
    rem = total - b * BANK_W;
    return (rem > BANK_W) ? BANK_W : rem;
  endfunction
endpackage

// File: rtl/lic_regdec.sv
module lic_regdec
  import lic_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 10,
  localparam int BSEL_W   = ADDR_W - 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BSEL_W-1:0] bank_sel
);
  logic [2:0] word;

  assign bank_sel = addr[ADDR_W-1:5];
  assign word     = addr[4:2];

  always_comb begin
    kind = RK_NONE;
    if (addr[1:0] == 2'b00 && int'(bank_sel) < NUM_BANKS) begin
      unique case (word)
        W_RISE:  kind = RK_RISE;
        W_FALL:  kind = RK_FALL;
        W_SWT:   kind = RK_SWT;
        W_PEND:  kind = RK_PEND;
        default: kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lic_bank.sv
module lic_bank
  import lic_pkg::*;
#(
  parameter int               LINES  = 32,
  parameter logic [LINES-1:0] DIRECT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic             wr_rise,
  input  logic             wr_fall,
  input  logic             wr_swt,
  input  logic             wr_pend,
  input  logic [LINES-1:0] wdata,
  input  reg_kind_e        rd_kind,
  output logic [31:0]      rdata,
  output logic [LINES-1:0] line_out
);
  localparam logic [LINES-1:0] CFG = ~DIRECT;

  logic [LINES-1:0] rise_q, fall_q, swt_q, pend_q, lvl_q, pulse_q;
  logic [LINES-1:0] sw_hit, rise_hit, fall_hit, hit, clr, lvl_d;

  // edge recognition against the stored level
  assign sw_hit   = wr_swt ? (wdata & CFG) : '0;
  assign rise_hit = CFG & rise_q & line_in & ~lvl_q;
  assign fall_hit = CFG & fall_q & ~line_in & lvl_q;
  assign hit      = rise_hit | fall_hit | sw_hit;
  assign clr      = wr_pend ? wdata : '0;

  // stored level moves only in a selected direction
  assign lvl_d = (lvl_q | (CFG & rise_q & line_in)) & ~(CFG & fall_q & ~line_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      swt_q   <= '0;
      pend_q  <= '0;
      lvl_q   <= '0;
      pulse_q <= '0;
    end else begin
      if (wr_rise) rise_q <= wdata & CFG;
      if (wr_fall) fall_q <= wdata & CFG;
      swt_q   <= (swt_q & ~clr) | sw_hit;
      pend_q  <= (pend_q & ~clr) | hit;
      lvl_q   <= lvl_d;
      pulse_q <= hit;
    end
  end

  assign line_out = (DIRECT & line_in) | (CFG & pulse_q);

  always_comb begin
    unique case (rd_kind)
      RK_RISE: rdata = 32'(rise_q);
      RK_FALL: rdata = 32'(fall_q);
      RK_SWT:  rdata = 32'(swt_q);
      RK_PEND: rdata = 32'(pend_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import lic_pkg::*;
#(
  parameter int                   NUM_LINES   = 40,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = 40'h00_A400_0000,
  localparam int                  NUM_BANKS   = (NUM_LINES + BANK_W - 1) / BANK_W,
  localparam int                  BSEL_W      = WIN_ADDR_W - 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irq_in,
  input  logic                  bus_we,
  input  logic [WIN_ADDR_W-1:0] bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_LINES-1:0]  irq_out
);
  reg_kind_e         kind;
  logic [BSEL_W-1:0] bank_sel;
  logic [31:0]       bank_rd [NUM_BANKS];

  lic_regdec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(WIN_ADDR_W)) u_dec (
    .addr(bus_addr), .kind(kind), .bank_sel(bank_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LN   = bank_lines(NUM_LINES, b);
    localparam int BASE = b * BANK_W;
    logic      sel;
    reg_kind_e rk;

    assign sel = (bank_sel == BSEL_W'(b));
    assign rk  = sel ? kind : RK_NONE;

    lic_bank #(.LINES(LN), .DIRECT(DIRECT_MASK[BASE +: LN])) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (irq_in[BASE +: LN]),
      .wr_rise  (bus_we && sel && kind == RK_RISE),
      .wr_fall  (bus_we && sel && kind == RK_FALL),
      .wr_swt   (bus_we && sel && kind == RK_SWT),
      .wr_pend  (bus_we && sel && kind == RK_PEND),
      .wdata    (bus_wdata[LN-1:0]),
      .rd_kind  (rk),
      .rdata    (bank_rd[b]),
      .line_out (irq_out[BASE +: LN])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_sel == BSEL_W'(b)) bus_rdata = bank_rd[b];
  end
endmodule

// File: rtl/lic_checker.sv
module lic_checker
  import lic_pkg::*;
#(
  parameter int                   NUM_LINES   = 40,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = 40'h00_A400_0000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LINES-1:0]  irq_in,
  input logic                  bus_we,
  input logic [WIN_ADDR_W-1:0] bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [31:0]           bus_rdata,
  input logic [NUM_LINES-1:0]  irq_out
);
  localparam int NB     = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int LAST_W = NUM_LINES - (NB - 1) * BANK_W;
  localparam logic [31:0] DIR0 = 32'(DIRECT_MASK);
  localparam logic [WIN_ADDR_W-1:0] PEND0 = WIN_ADDR_W'(8'h14);
  localparam logic [WIN_ADDR_W-1:0] SWT0  = WIN_ADDR_W'(8'h10);

  logic in_bank0_reg, in_last_reg;
  assign in_bank0_reg = bus_addr[1:0] == 2'b00 && bus_addr[WIN_ADDR_W-1:5] == '0 &&
                        bus_addr[4:2] >= W_RISE && bus_addr[4:2] <= W_PEND;
  assign in_last_reg  = bus_addr[1:0] == 2'b00 && int'(bus_addr[WIN_ADDR_W-1:5]) == NB - 1 &&
                        bus_addr[4:2] >= W_RISE && bus_addr[4:2] <= W_PEND;

  // R3: direct outputs mirror direct inputs
  assert_direct_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out ^ irq_in) & DIRECT_MASK) == '0);

  // R4: direct-line bits never show in bank-0 registers
  assert_direct_bits_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_bank0_reg |-> (bus_rdata & DIR0) == '0);

  // R8: pending bits only fall after a write
  assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == PEND0 && $past(bus_addr) == PEND0 && !$past(bus_we))
      |-> ($past(bus_rdata) & ~bus_rdata) == '0);

  // R9: every configurable bit written to the software trigger pulses next cycle
  assert_swtrig_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_we && bus_addr == SWT0)
      |-> (irq_out[31:0] & $past(bus_wdata) & ~DIR0) == ($past(bus_wdata) & ~DIR0));

  // R10: bits above the last line read zero
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_last_reg |-> (64'(bus_rdata) >> LAST_W) == '0);

  // R11: addresses outside the banks read zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr[WIN_ADDR_W-1:5]) >= NB || bus_addr[1:0] != 2'b00) |-> bus_rdata == '0);
endmodule

bind line_irq_ctrl lic_checker #(.NUM_LINES(NUM_LINES), .DIRECT_MASK(DIRECT_MASK)) u_chk (.*);

// File: tb/line_irq_ctrl_bench.sv
`timescale 1ns/1ps
module line_irq_ctrl_bench;
  localparam int NL = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          bus_we = 1'b0;
  logic [9:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_out;

  always #10 clk = ~clk;   // 50 MHz

  line_irq_ctrl u_line_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  localparam logic [9:0] RISE0 = 10'h08, FALL0 = 10'h0C, SWT0 = 10'h10, PEND0 = 10'h14;
  localparam logic [9:0] RISE1 = 10'h28, FALL1 = 10'h2C, SWT1 = 10'h30, PEND1 = 10'h34;

  typedef struct {
    bit            is_rd;
    string         tag;
    logic [NL-1:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_fail = 0;

  // monitor: pops expectations and compares with the outputs
  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.is_rd) begin
        if (bus_rdata !== it.exp[31:0]) begin
          n_fail++;
          $display("FAIL %s: rdata actual=%h expected=%h", it.tag, bus_rdata, it.exp[31:0]);
        end
      end else if (irq_out !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irq_out actual=%h expected=%h", it.tag, irq_out, it.exp);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    #1;
    it.is_rd = 1'b1; it.tag = tag; it.exp = NL'(e);
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic ochk(input logic [NL-1:0] e, input string tag);
    item_t it;
    #1;
    it.is_rd = 1'b0; it.tag = tag; it.exp = e;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  function automatic logic [NL-1:0] bitv(input int n);
    return NL'(1) << n;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    ochk('0, "R1 outputs low after reset");
    rd(RISE0, 0, "R1 rise0"); rd(FALL0, 0, "R1 fall0");
    rd(SWT0, 0, "R1 swt0");   rd(PEND0, 0, "R1 pend0");
    rd(RISE1, 0, "R1 rise1"); rd(FALL1, 0, "R1 fall1");
    rd(SWT1, 0, "R1 swt1");   rd(PEND1, 0, "R1 pend1");

    // R3 direct passthrough
    irq_in[26] = 1'b1; irq_in[29] = 1'b1;
    ochk(bitv(26) | bitv(29), "R3 direct level passes");
    tick();
    rd(PEND0, 0, "R3 direct sets no pending");
    irq_in = '0;
    ochk('0, "R3 direct level falls");

    // R4 direct bits ignore writes
    wr(RISE0, 32'hFFFF_FFFF);
    rd(RISE0, 32'h5BFF_FFFF, "R4 direct rise bits read 0");
    wr(SWT0, 32'h0400_0000);
    ochk('0, "R4 swtrig on direct line no pulse");
    rd(SWT0, 0, "R4 swt direct bit 0");
    rd(PEND0, 0, "R4 pend direct bit 0");

    // R5 rising edge, one-cycle pulse, no retrigger
    irq_in[3] = 1'b1;
    tick(); ochk(bitv(3), "R5 rising pulse");
    tick(); ochk('0, "R5 pulse one cycle");
    rd(PEND0, 32'h8, "R5 pending set");
    tick(); ochk('0, "R5 held high no retrigger");

    // R7 rise-only line: fall then rise gives nothing
    irq_in[3] = 1'b0;
    tick(); ochk('0, "R7 fall on rise-only line");
    irq_in[3] = 1'b1;
    tick(); ochk('0, "R7 stale level blocks second rise");

    // R8 pending clear semantics
    wr(PEND0, 32'h0);
    rd(PEND0, 32'h8, "R8 write 0 keeps pending");
    wr(PEND0, 32'h8);
    rd(PEND0, 32'h0, "R8 write 1 clears pending");

    // R6 both directions on line 5, fall-only on line 7
    wr(RISE0, 32'h20);
    wr(FALL0, 32'hA0);
    rd(FALL0, 32'hA0, "R6 fall select readback");
    irq_in[5] = 1'b1;
    tick(); ochk(bitv(5), "R5 rising pulse line 5");
    tick(); ochk('0, "R5 line 5 pulse ends");
    irq_in[5] = 1'b0;
    tick(); ochk(bitv(5), "R6 falling pulse line 5");
    irq_in[7] = 1'b1;
    tick(); ochk('0, "R7 rise on fall-only line");
    irq_in[7] = 1'b0;
    tick(); ochk('0, "R7 fall-only line never fires");
    rd(PEND0, 32'h20, "R6 pending line 5 only");
    wr(PEND0, 32'hFFFF_FFFF);
    rd(PEND0, 32'h0, "R8 clear all");

    // R2 / R10 second bank
    wr(RISE1, 32'hFFFF_FFFF);
    rd(RISE1, 32'hFF, "R10 upper bits read 0");
    irq_in[35] = 1'b1;
    tick(); ochk(bitv(35), "R2 line 35 pulse");
    rd(PEND1, 32'h8, "R2 line 35 at bank1 bit 3");
    rd(PEND0, 32'h0, "R2 bank0 untouched");
    wr(PEND1, 32'hFFFF_FFFF);
    rd(PEND1, 32'h0, "R10 clear bank1");
    irq_in[35] = 1'b0;

    // R9 software trigger
    wr(SWT0, 32'h1);
    ochk(bitv(0), "R9 swtrig pulse");
    rd(SWT0, 32'h1, "R9 swt bit held");
    rd(PEND0, 32'h1, "R9 pending set");
    tick(); ochk('0, "R9 pulse one cycle");
    wr(PEND0, 32'h1);
    rd(SWT0, 32'h0, "R9 swt cleared with pending");
    rd(PEND0, 32'h0, "R9 pending cleared");

    // R11 unmapped and misaligned
    wr(10'h200, 32'hFFFF_FFFF);
    rd(10'h200, 32'h0, "R11 out-of-bank reads 0");
    rd(10'h004, 32'h0, "R11 unused word reads 0");
    wr(10'h009, 32'hFFFF_FFFF);
    rd(10'h009, 32'h0, "R11 misaligned reads 0");
    rd(RISE0, 32'h20, "R11 registers unchanged");

    tick();
    finish_run();
  end
endmodule